// File: doc/BRIEF.md
# General-Purpose Output Line Bank

This block holds the per-line output control for a bank of general-purpose I/O lines and computes the value and drive enable seen by each pad. A simple register bus (write strobe, address, write data, combinational read data) programs the bank. Every control field has a write-one-to-set address, a write-one-to-clear address and a read-only status view. Zero bits in a set or clear write leave the field as it was.

Each line is driven either by the bank's own direction and output-data registers or by one of four peripheral functions. A per-line 2-bit function code selects the peripheral. The output data can also be written directly, with a programmable write mask. One access can then raise some lines and lower others. An open-drain option turns any line into a drive-low-only line. Pin levels come back through a two-flop synchroniser and can be read from a pin status address.

Top module: `gpio_out_bank`

Register map (5-bit word address): 0 own-set, 1 own-clear, 2 own-status, 3 drive-set, 4 drive-clear, 5 drive-status, 6 level-set, 7 level-clear, 8 level (direct masked write / read), 9 mask-set, 10 mask-clear, 11 mask-status, 12 drain-set, 13 drain-clear, 14 drain-status, 15 function code bit 0 (read/write), 16 function code bit 1 (read/write), 17 pin status (read-only). Bit i of every address belongs to line i.

## Requirements
- R1: After reset the own, drive, level, mask, drain and function-code registers read zero. Every line is under peripheral control with function code 00.
- R2: A write to drive-set (3) sets the drive status bits where the write data is 1. A write to drive-clear (4) clears them. Zero bits leave the status unchanged, and drive-status (5) reads the result.
- R3: Writes to level-set (6) and level-clear (7) set and clear the matching output-level bits. Zero bits leave the level unchanged, and address 8 reads the level.
- R4: A write to address 8 changes only the level bits whose mask bit is 1. Bits with mask 0 keep their value.
- R5: Mask bits are set through 9 and cleared through 10, and read back at 11. They reset to zero, so a direct write to 8 right after reset changes nothing.
- R6: With own bit = 1 (set via 0, cleared via 1) and drain = 0, pin_oe equals the drive bit and pin_out equals the level bit of that line.
- R7: With own bit = 0 the line uses the function code {bit1 from address 16, bit0 from address 15}, with 00=A, 01=B, 10=C, 11=D. pin_oe[i] = per_oe[code*N+i] and pin_out[i] = per_out[code*N+i].
- R8: Drive and level writes update their status even while the line is under peripheral control, and the pins still follow the peripheral.
- R9: With drain bit = 1 (set via 12, cleared via 13), pin_out is 0 and pin_oe is the selected enable AND NOT the selected value. This holds under both own and peripheral control.
- R10: The pin status (17) shows pin_in as sampled two clock edges earlier.
- R11: Reads of any set or clear address return zero. A write takes effect on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Word address |
| wdata | input | NLINES | Write data |
| rdata | output | NLINES | Read data for addr (combinational) |
| per_out | input | 4*NLINES | Peripheral values, function f at bits f*NLINES+i |
| per_oe | input | 4*NLINES | Peripheral drive enables, same layout |
| pin_in | input | NLINES | Pad levels |
| pin_out | output | NLINES | Value to pad |
| pin_oe | output | NLINES | Drive enable to pad |

## Verification
Register writes show on the read port and on pin_out and pin_oe after one rising edge. The bench drives a write at a falling edge, releases it at the next falling edge and samples there. Reads are combinational, so the bench checks them a nanosecond after it changes the address. Pin status is due two edges after pin_in changes. The bench checks it after one edge, when it must still hold the old value, and again after two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 5;
    localparam int NFUNC  = 4;

    localparam logic [ADDR_W-1:0] A_OWN_SET  = 5'd0;
    localparam logic [ADDR_W-1:0] A_OWN_CLR  = 5'd1;
    localparam logic [ADDR_W-1:0] A_OWN_STAT = 5'd2;
    localparam logic [ADDR_W-1:0] A_DRV_SET  = 5'd3;
    localparam logic [ADDR_W-1:0] A_DRV_CLR  = 5'd4;
    localparam logic [ADDR_W-1:0] A_DRV_STAT = 5'd5;
    localparam logic [ADDR_W-1:0] A_LVL_SET  = 5'd6;
    localparam logic [ADDR_W-1:0] A_LVL_CLR  = 5'd7;
    localparam logic [ADDR_W-1:0] A_LVL      = 5'd8;
    localparam logic [ADDR_W-1:0] A_MSK_SET  = 5'd9;
    localparam logic [ADDR_W-1:0] A_MSK_CLR  = 5'd10;
    localparam logic [ADDR_W-1:0] A_MSK_STAT = 5'd11;
    localparam logic [ADDR_W-1:0] A_ODN_SET  = 5'd12;
    localparam logic [ADDR_W-1:0] A_ODN_CLR  = 5'd13;
    localparam logic [ADDR_W-1:0] A_ODN_STAT = 5'd14;
    localparam logic [ADDR_W-1:0] A_FSEL0    = 5'd15;
    localparam logic [ADDR_W-1:0] A_FSEL1    = 5'd16;
    localparam logic [ADDR_W-1:0] A_PIN_STAT = 5'd17;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    input  logic [NLINES-1:0] pin_stat,
    output logic [NLINES-1:0] rdata,
    output logic [NLINES-1:0] own,
    output logic [NLINES-1:0] drv,
    output logic [NLINES-1:0] lvl,
    output logic [NLINES-1:0] odn,
    output logic [NLINES-1:0] fsel0,
    output logic [NLINES-1:0] fsel1
);
    typedef struct packed {
        logic [NLINES-1:0] own;
        logic [NLINES-1:0] drv;
        logic [NLINES-1:0] lvl;
        logic [NLINES-1:0] msk;
        logic [NLINES-1:0] odn;
        logic [NLINES-1:0] fs0;
        logic [NLINES-1:0] fs1;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (addr)
                A_OWN_SET: regs_d.own = regs_q.own | wdata;
                A_OWN_CLR: regs_d.own = regs_q.own & ~wdata;
                A_DRV_SET: regs_d.drv = regs_q.drv | wdata;
                A_DRV_CLR: regs_d.drv = regs_q.drv & ~wdata;
                A_LVL_SET: regs_d.lvl = regs_q.lvl | wdata;
                A_LVL_CLR: regs_d.lvl = regs_q.lvl & ~wdata;
                A_LVL:     regs_d.lvl = (regs_q.lvl & ~regs_q.msk) | (wdata & regs_q.msk);
                A_MSK_SET: regs_d.msk = regs_q.msk | wdata;
                A_MSK_CLR: regs_d.msk = regs_q.msk & ~wdata;
                A_ODN_SET: regs_d.odn = regs_q.odn | wdata;
                A_ODN_CLR: regs_d.odn = regs_q.odn & ~wdata;
                A_FSEL0:   regs_d.fs0 = wdata;
                A_FSEL1:   regs_d.fs1 = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (addr)
            A_OWN_STAT: rdata = regs_q.own;
            A_DRV_STAT: rdata = regs_q.drv;
            A_LVL:      rdata = regs_q.lvl;
            A_MSK_STAT: rdata = regs_q.msk;
            A_ODN_STAT: rdata = regs_q.odn;
            A_FSEL0:    rdata = regs_q.fs0;
            A_FSEL1:    rdata = regs_q.fs1;
            A_PIN_STAT: rdata = pin_stat;
            default:    rdata = '0;
        endcase
    end

    assign own   = regs_q.own;
    assign drv   = regs_q.drv;
    assign lvl   = regs_q.lvl;
    assign odn   = regs_q.odn;
    assign fsel0 = regs_q.fs0;
    assign fsel1 = regs_q.fs1;

    AST_DRV_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == A_DRV_SET) |-> ((regs_q.drv & $past(wdata)) == $past(wdata))); // R2
    AST_LVL_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == A_LVL_CLR) |-> ((regs_q.lvl & $past(wdata)) == '0)); // R3
    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == A_LVL) |-> (((regs_q.lvl ^ $past(regs_q.lvl)) & ~$past(regs_q.msk)) == '0)); // R4
endmodule

// File: rtl/gpio_line_mux.sv
module gpio_line_mux
    import gpio_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic [NLINES-1:0]       own,
    input  logic [NLINES-1:0]       drv,
    input  logic [NLINES-1:0]       lvl,
    input  logic [NLINES-1:0]       odn,
    input  logic [NLINES-1:0]       fsel0,
    input  logic [NLINES-1:0]       fsel1,
    input  logic [NFUNC*NLINES-1:0] per_out,
    input  logic [NFUNC*NLINES-1:0] per_oe,
    output logic [NLINES-1:0]       pin_out,
    output logic [NLINES-1:0]       pin_oe
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [1:0] code;
        logic       sel_val;
        logic       sel_oe;
        assign code    = {fsel1[i], fsel0[i]};
        assign sel_val = own[i] ? lvl[i] : per_out[int'(code)*NLINES + i];
        assign sel_oe  = own[i] ? drv[i] : per_oe[int'(code)*NLINES + i];
        assign pin_out[i] = odn[i] ? 1'b0 : sel_val;
        assign pin_oe[i]  = odn[i] ? (sel_oe & ~sel_val) : sel_oe;
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_stat
);
    typedef struct packed {
        logic [NLINES-1:0] s1;
        logic [NLINES-1:0] s2;
        logic [1:0]        age;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.s1  = pin_in;
        sync_d.s2  = sync_q.s1;
        if (sync_q.age != 2'd2) sync_d.age = sync_q.age + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pin_stat = sync_q.s2;

    AST_PIN_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q.age == 2'd2) |-> (pin_stat == $past(pin_in, 2))); // R10
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
    import gpio_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [4:0]               addr,
    input  logic [NLINES-1:0]        wdata,
    output logic [NLINES-1:0]        rdata,
    input  logic [4*NLINES-1:0]      per_out,
    input  logic [4*NLINES-1:0]      per_oe,
    input  logic [NLINES-1:0]        pin_in,
    output logic [NLINES-1:0]        pin_out,
    output logic [NLINES-1:0]        pin_oe
);
    logic [NLINES-1:0] own, drv, lvl, odn, fsel0, fsel1, pin_stat;

    gpio_regfile #(.NLINES(NLINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pin_stat(pin_stat), .rdata(rdata), .own(own), .drv(drv), .lvl(lvl),
        .odn(odn), .fsel0(fsel0), .fsel1(fsel1)
    );

    gpio_line_mux #(.NLINES(NLINES)) u_mux (
        .own(own), .drv(drv), .lvl(lvl), .odn(odn), .fsel0(fsel0), .fsel1(fsel1),
        .per_out(per_out), .per_oe(per_oe), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    gpio_pin_sync #(.NLINES(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_stat(pin_stat)
    );

    AST_DRAIN_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((odn & pin_oe & pin_out) == '0) && ((odn & pin_out) == '0)); // R9
endmodule

// File: tb/gpio_out_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_out_bank_tb_top;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [4:0]     addr = 5'd0;
    logic [N-1:0]   wdata = '0;
    logic [N-1:0]   rdata;
    logic [4*N-1:0] per_out = 16'h3C96;
    logic [4*N-1:0] per_oe  = 16'hA5C3;
    logic [N-1:0]   pin_in = '0;
    logic [N-1:0]   pin_out, pin_oe;

    int n_run = 0;
    int n_fail = 0;
    logic [N-1:0] m_lvl;

    always #2.5 clk = ~clk;

    gpio_out_bank #(.NLINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .per_out(per_out), .per_oe(per_oe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [N-1:0] per_sel(input logic [4*N-1:0] v, input logic [N-1:0] f0,
                                             input logic [N-1:0] f1);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = v[(2*f1[i] + f0[i])*N + i];
        return r;
    endfunction

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a <= 16; a++) begin
            rd(5'(a), d);
            chk("R1 status zero", d, '0);
        end
        chk("R1 pin_oe func A", pin_oe, per_oe[N-1:0]);
        chk("R1 pin_out func A", pin_out, per_out[N-1:0]);

        // R5: mask reset zero, direct write ignored
        wr(5'd8, 4'hF);
        rd(5'd8, d); chk("R5 direct write after reset", d, 4'h0);
        m_lvl = '0;

        // R2/R8: drive under peripheral control
        wr(5'd3, 4'b0101);
        rd(5'd5, d); chk("R2 drive set", d, 4'b0101);
        wr(5'd4, 4'b0001);
        rd(5'd5, d); chk("R2 drive clear", d, 4'b0100);
        chk("R8 pins follow peripheral", pin_oe, per_oe[N-1:0]);

        // R3/R8: level set/clear
        wr(5'd6, 4'b1011);
        rd(5'd8, d); chk("R3 level set", d, 4'b1011);
        wr(5'd7, 4'b0010);
        rd(5'd8, d); chk("R3 level clear", d, 4'b1001);
        wr(5'd7, 4'b0000);
        rd(5'd8, d); chk("R3 zero clear no effect", d, 4'b1001);
        chk("R8 pin_out still peripheral", pin_out, per_out[N-1:0]);
        m_lvl = 4'b1001;

        // R11: set/clear addresses read zero
        for (int a = 0; a <= 13; a++) begin
            if (a == 0 || a == 1 || a == 3 || a == 4 || a == 6 || a == 7 ||
                a == 9 || a == 10 || a == 12 || a == 13) begin
                rd(5'(a), d); chk("R11 set/clear reads zero", d, '0);
            end
        end

        // R11: write not visible before the edge
        @(negedge clk);
        wr_en = 1'b1; addr = 5'd9; wdata = 4'b0110;
        #1;
        chk("R11 no effect before edge", rdata, '0);
        @(negedge clk);
        wr_en = 1'b0;
        rd(5'd11, d); chk("R5 mask set", d, 4'b0110);

        // R4/R5: sweep masks and values
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 16; v++) begin
                wr(5'd10, 4'hF);
                wr(5'd9, 4'(m));
                wr(5'd8, 4'(v));
                m_lvl = (m_lvl & ~4'(m)) | (4'(v) & 4'(m));
                rd(5'd8, d); chk("R4 masked direct write", d, m_lvl);
            end
        end
        rd(5'd11, d); chk("R5 mask readback", d, 4'hF);

        // R6: own control sweep
        wr(5'd0, 4'hF);
        rd(5'd2, d); chk("R6 own status", d, 4'hF);
        for (int dv = 0; dv < 16; dv++) begin
            for (int lv = 0; lv < 16; lv++) begin
                wr(5'd4, 4'hF); wr(5'd3, 4'(dv));
                wr(5'd7, 4'hF); wr(5'd6, 4'(lv));
                chk("R6 pin_oe from drive", pin_oe, 4'(dv));
                chk("R6 pin_out from level", pin_out, 4'(lv));
            end
        end

        // R9: open drain under own control (drive 1111, level 0101)
        wr(5'd3, 4'hF); wr(5'd7, 4'hF); wr(5'd6, 4'b0101);
        wr(5'd12, 4'hF);
        rd(5'd14, d); chk("R9 drain status", d, 4'hF);
        chk("R9 own pin_out low", pin_out, 4'b0000);
        chk("R9 own pin_oe", pin_oe, 4'b1010);

        // R7/R9: peripheral control, every uniform code then mixed codes
        wr(5'd1, 4'hF);
        for (int c = 0; c < 4; c++) begin
            logic [N-1:0] f0, f1, ev, ee;
            f0 = (c & 1) ? 4'hF : 4'h0;
            f1 = (c & 2) ? 4'hF : 4'h0;
            wr(5'd15, f0); wr(5'd16, f1);
            ev = per_sel(per_out, f0, f1);
            ee = per_sel(per_oe, f0, f1);
            chk("R9 periph pin_out low", pin_out, 4'b0000);
            chk("R9 periph pin_oe", pin_oe, ee & ~ev);
        end
        wr(5'd13, 4'hF);
        for (int c = 0; c < 4; c++) begin
            logic [N-1:0] f0, f1;
            f0 = (c & 1) ? 4'hF : 4'h0;
            f1 = (c & 2) ? 4'hF : 4'h0;
            wr(5'd15, f0); wr(5'd16, f1);
            chk("R7 uniform code pin_out", pin_out, per_out[c*N +: N]);
            chk("R7 uniform code pin_oe", pin_oe, per_oe[c*N +: N]);
        end
        wr(5'd15, 4'b1010); wr(5'd16, 4'b1100);
        chk("R7 mixed codes pin_out", pin_out, per_sel(per_out, 4'b1010, 4'b1100));
        chk("R7 mixed codes pin_oe", pin_oe, per_sel(per_oe, 4'b1010, 4'b1100));

        // R10: pin readback latency
        for (int p = 1; p < 16; p++) begin
            logic [N-1:0] prev;
            rd(5'd17, prev);
            @(negedge clk);
            pin_in = 4'(p);
            @(negedge clk);
            rd(5'd17, d); chk("R10 one edge old value", d, prev);
            @(negedge clk);
            rd(5'd17, d); chk("R10 two edges new value", d, 4'(p));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule